// File: doc/BRIEF.md
# Byte FIFO Pair Control Unit

This block holds the control state for a pair of byte queues in a serial port, one on the transmit path and one on the receive path. A host writes an 8-bit control byte. Bit 0 selects queued operation: when it is 1 both queues hold up to `DEPTH` bytes, and when it is 0 each path falls back to a one-byte holding register. Bits 1 and 2 request an emptying of the receive and transmit queue respectively. These bits have an effect only when bit 0 is 1 in the same write. A write with bit 0 equal to 0 can only switch the block from queued to holding operation.

A small controller with four states (`ST_OFF`, `ST_ON`, `ST_FLUSH_ON`, `ST_FLUSH_OFF`) turns each accepted write into a single-cycle clear pulse. That pulse resets the pointers and the level counter of the selected queue. Stored bytes and the serial shift registers outside this block are not touched. A request bit is never stored beyond that pulse, so no software action is needed to rearm it.

The transitions are as follows:
- `OFF→FLUSH_ON` on an enabling write.
- `ON→FLUSH_ON` on an enabling write that carries a clear request.
- `ON→FLUSH_OFF` on a disabling write.
- `FLUSH_ON→ON` and `FLUSH_OFF→OFF` after one cycle, unless a new write arrives. A new write is then decoded as if the controller were already in the target state.
- Every other case holds the state.

The block reports level, full, empty and threshold flags for each queue, plus a sticky receive overrun flag.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, `fifo_en` is 0, both levels are 0, both empty flags are 1, and `rx_overrun` is 0.
- R2: A write with bit 0 = 1 while the queues are off sets `fifo_en` at the write edge. Both queues are emptied at the following edge.
- R3: A write with bit 0 = 0 while on empties both queues and clears `fifo_en` at the edge after the write edge. A write with bit 0 = 0 while off changes nothing, even if bits 1 or 2 are 1.
- R4: A write with bits 0 and 1 = 1 sets `rx_level` to 0 at the edge after the write edge. The transmit queue is left unchanged.
- R5: A write with bits 0 and 2 = 1 sets `tx_level` to 0 at the edge after the write edge. The receive queue is left unchanged.
- R6: The clear request self-clears: the queue is emptied exactly once, and a push in the cycle after the clear edge is kept.
- R7: With queues on, each queue holds `DEPTH` (128) bytes and `*_full` is 1 at level 128. A push while full is ignored and the level stays at 128.
- R8: Bytes leave in arrival order, and `*_q` shows the oldest byte. A pop while the queue is empty is ignored.
- R9: With queues off, each path holds at most one byte. A second push is ignored and the first byte is kept.
- R10: `rx_overrun` becomes 1 after a receive push while the receive queue is full. It stays 1 until the next receive queue clear.
- R11: If a clear and a push to the same queue fall in the same cycle, the queue is empty afterwards.
- R12: `rx_trig` is 1 when `rx_level` >= `RX_TRIG` (8). `tx_trig` is 1 when `tx_level` <= `TX_TRIG` (16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_data | input | 8 | Control byte: bit 0 enable, bit 1 receive clear, bit 2 transmit clear |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_data | input | 8 | Transmit byte to push |
| tx_pop | input | 1 | Remove the oldest transmit byte |
| tx_q | output | 8 | Oldest transmit byte |
| rx_push | input | 1 | Push a byte into the receive queue |
| rx_data | input | 8 | Receive byte to push |
| rx_pop | input | 1 | Remove the oldest receive byte |
| rx_q | output | 8 | Oldest receive byte |
| fifo_en | output | 1 | Queued operation active |
| tx_level | output | 8 | Transmit queue level, 0 to 128 |
| rx_level | output | 8 | Receive queue level, 0 to 128 |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_overrun | output | 1 | Sticky: a receive push was lost |
| tx_trig | output | 1 | Transmit level at or below threshold |
| rx_trig | output | 1 | Receive level at or above threshold |

## Verification
The properties assume that every input is at a known value from the first clock after reset. The check that a clear pulse lasts exactly one cycle only holds when no control write lands in the flush cycle itself, since such a write may legally start a second flush. The stimulus therefore always leaves at least one idle cycle after each control write. It does drive a push into the flush cycle on purpose, because that is the case the clear must override.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic [1:0] {
        ST_OFF       = 2'd0,
        ST_ON        = 2'd1,
        ST_FLUSH_ON  = 2'd2,
        ST_FLUSH_OFF = 2'd3
    } fctl_state_e;

    localparam int unsigned CTL_EN_BIT  = 0;
    localparam int unsigned CTL_RXC_BIT = 1;
    localparam int unsigned CTL_TXC_BIT = 2;

endpackage

// File: rtl/uart_fifo_ctl_fsm.sv
module uart_fifo_ctl_fsm
    import uart_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_data,
    output logic       fifo_en,
    output logic       rx_clr,
    output logic       tx_clr
);

    fctl_state_e state, state_n;
    logic        pend_rx, pend_rx_n;
    logic        pend_tx, pend_tx_n;
    logic        cur_on;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            pend_rx <= 1'b0;
            pend_tx <= 1'b0;
        end else begin
            state   <= state_n;
            pend_rx <= pend_rx_n;
            pend_tx <= pend_tx_n;
        end
    end

    // next state: flush states decode writes as their target state
    always_comb begin
        unique case (state)
            ST_OFF, ST_FLUSH_OFF: cur_on = 1'b0;
            ST_ON, ST_FLUSH_ON:   cur_on = 1'b1;
            default:              cur_on = 1'b0;
        endcase
        state_n   = cur_on ? ST_ON : ST_OFF;
        pend_rx_n = 1'b0;
        pend_tx_n = 1'b0;
        if (ctl_wr) begin
            if (ctl_data[CTL_EN_BIT] && !cur_on) begin
                state_n   = ST_FLUSH_ON;
                pend_rx_n = 1'b1;
                pend_tx_n = 1'b1;
            end else if (ctl_data[CTL_EN_BIT] &&
                         (ctl_data[CTL_RXC_BIT] || ctl_data[CTL_TXC_BIT])) begin
                state_n   = ST_FLUSH_ON;
                pend_rx_n = ctl_data[CTL_RXC_BIT];
                pend_tx_n = ctl_data[CTL_TXC_BIT];
            end else if (!ctl_data[CTL_EN_BIT] && cur_on) begin
                state_n   = ST_FLUSH_OFF;
                pend_rx_n = 1'b1;
                pend_tx_n = 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        fifo_en = 1'b0;
        rx_clr  = 1'b0;
        tx_clr  = 1'b0;
        unique case (state)
            ST_OFF: ;
            ST_ON:  fifo_en = 1'b1;
            ST_FLUSH_ON, ST_FLUSH_OFF: begin
                fifo_en = 1'b1;
                rx_clr  = pend_rx;
                tx_clr  = pend_tx;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int unsigned DEPTH  = 128,
    parameter int unsigned DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           single,
    input  logic                           push,
    input  logic [DATA_W-1:0]              din,
    input  logic                           pop,
    output logic [DATA_W-1:0]              dout,
    output logic [$clog2(DEPTH+1)-1:0]     level,
    output logic                           full,
    output logic                           empty,
    output logic                           ovf
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned LVL_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [LVL_W-1:0]  cap;
    logic              push_ok, pop_ok;

    assign cap     = single ? LVL_W'(1) : LVL_W'(DEPTH);
    assign full    = (level >= cap);
    assign empty   = (level == '0);
    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;
    assign ovf     = push && full && !clr;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            level <= level + LVL_W'(push_ok) - LVL_W'(pop_ok);
        end
    end

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
    parameter int unsigned DEPTH   = 128,
    parameter int unsigned RX_TRIG = 8,
    parameter int unsigned TX_TRIG = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctl_wr,
    input  logic [7:0]                 ctl_data,
    input  logic                       tx_push,
    input  logic [7:0]                 tx_data,
    input  logic                       tx_pop,
    output logic [7:0]                 tx_q,
    input  logic                       rx_push,
    input  logic [7:0]                 rx_data,
    input  logic                       rx_pop,
    output logic [7:0]                 rx_q,
    output logic                       fifo_en,
    output logic [$clog2(DEPTH+1)-1:0] tx_level,
    output logic [$clog2(DEPTH+1)-1:0] rx_level,
    output logic                       tx_empty,
    output logic                       tx_full,
    output logic                       rx_empty,
    output logic                       rx_full,
    output logic                       rx_overrun,
    output logic                       tx_trig,
    output logic                       rx_trig
);

    localparam int unsigned LVL_W = $clog2(DEPTH+1);

    logic rx_clr, tx_clr;
    logic rx_ovf, tx_ovf_unused;

    uart_fifo_ctl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_data (ctl_data),
        .fifo_en  (fifo_en),
        .rx_clr   (rx_clr),
        .tx_clr   (tx_clr)
    );

    uart_byte_fifo #(.DEPTH(DEPTH), .DATA_W(8)) u_tx_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tx_clr),
        .single (!fifo_en),
        .push   (tx_push),
        .din    (tx_data),
        .pop    (tx_pop),
        .dout   (tx_q),
        .level  (tx_level),
        .full   (tx_full),
        .empty  (tx_empty),
        .ovf    (tx_ovf_unused)
    );

    uart_byte_fifo #(.DEPTH(DEPTH), .DATA_W(8)) u_rx_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (rx_clr),
        .single (!fifo_en),
        .push   (rx_push),
        .din    (rx_data),
        .pop    (rx_pop),
        .dout   (rx_q),
        .level  (rx_level),
        .full   (rx_full),
        .empty  (rx_empty),
        .ovf    (rx_ovf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rx_overrun <= 1'b0;
        else if (rx_clr) rx_overrun <= 1'b0;
        else if (rx_ovf) rx_overrun <= 1'b1;
    end

    assign rx_trig = (rx_level >= LVL_W'(RX_TRIG));
    assign tx_trig = (tx_level <= LVL_W'(TX_TRIG));

endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
    parameter int unsigned DEPTH = 128
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ctl_wr,
    input logic [7:0]                 ctl_data,
    input logic                       fifo_en,
    input logic                       rx_clr,
    input logic                       tx_clr,
    input logic                       rx_push,
    input logic                       rx_pop,
    input logic                       rx_full,
    input logic                       rx_overrun,
    input logic [$clog2(DEPTH+1)-1:0] rx_level,
    input logic [$clog2(DEPTH+1)-1:0] tx_level
);

    localparam int unsigned LVL_W = $clog2(DEPTH+1);

    a_r3_off_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_data[0] && !fifo_en) |=> (!rx_clr && !tx_clr && !fifo_en));

    a_r4_rx_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |=> (rx_level == '0));

    a_r6_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr && !ctl_wr) |=> !rx_clr);

    a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level <= LVL_W'(DEPTH)) && (tx_level <= LVL_W'(DEPTH)));

    a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !rx_clr && !rx_pop) |=> (rx_level == $past(rx_level)));

    a_r9_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (rx_level <= LVL_W'(1)) && (tx_level <= LVL_W'(1)));

    a_r10_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !rx_clr) |=> rx_overrun);

endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_data   (ctl_data),
    .fifo_en    (fifo_en),
    .rx_clr     (rx_clr),
    .tx_clr     (tx_clr),
    .rx_push    (rx_push),
    .rx_pop     (rx_pop),
    .rx_full    (rx_full),
    .rx_overrun (rx_overrun),
    .rx_level   (rx_level),
    .tx_level   (tx_level)
);

// File: tb/uart_fifo_ctl_tb.sv
`timescale 1ns/1ps
module uart_fifo_ctl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_data = '0;
    logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_data = '0, rx_data = '0;
    logic [7:0] tx_q, rx_q, tx_level, rx_level;
    logic       fifo_en, tx_empty, tx_full, rx_empty, rx_full, rx_overrun, tx_trig, rx_trig;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    uart_fifo_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
        .tx_push(tx_push), .tx_data(tx_data), .tx_pop(tx_pop), .tx_q(tx_q),
        .rx_push(rx_push), .rx_data(rx_data), .rx_pop(rx_pop), .rx_q(rx_q),
        .fifo_en(fifo_en), .tx_level(tx_level), .rx_level(rx_level),
        .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
        .rx_overrun(rx_overrun), .tx_trig(tx_trig), .rx_trig(rx_trig)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push_rx(input logic [7:0] d);
        rx_push = 1'b1; rx_data = d;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] d);
        tx_push = 1'b1; tx_data = d;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop_rx();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    // write, then wait for the flush edge
    task automatic write_ctl(input logic [7:0] d);
        ctl_wr = 1'b1; ctl_data = d;
        @(negedge clk);
        ctl_wr = 1'b0;
        @(negedge clk);
    endtask

    // {op, data, expected rx_level, expected rx_q}; op 0 push, 1 pop, 2 control write
    localparam int NVEC = 14;
    localparam logic [25:0] VEC [NVEC] = '{
        {2'd2, 8'h01, 8'd0, 8'h00},  // R2 enable
        {2'd0, 8'h11, 8'd1, 8'h11},  // R8
        {2'd0, 8'h22, 8'd2, 8'h11},  // R8
        {2'd0, 8'h33, 8'd3, 8'h11},  // R8
        {2'd1, 8'h00, 8'd2, 8'h22},  // R8 oldest first
        {2'd2, 8'h03, 8'd0, 8'h00},  // R4 receive clear
        {2'd1, 8'h00, 8'd0, 8'h00},  // R8 pop on empty
        {2'd0, 8'h44, 8'd1, 8'h44},
        {2'd2, 8'h05, 8'd1, 8'h44},  // R5 receive untouched
        {2'd2, 8'h00, 8'd0, 8'h00},  // R3 disable empties
        {2'd0, 8'h55, 8'd1, 8'h55},  // R9
        {2'd0, 8'h66, 8'd1, 8'h55},  // R9 second byte dropped
        {2'd2, 8'h06, 8'd1, 8'h55},  // R3 ignored while off
        {2'd1, 8'h00, 8'd0, 8'h00}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int bad_order;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 fifo_en", fifo_en, 0);
        check("R1 levels", rx_level + tx_level, 0);
        check("R1 empty", rx_empty & tx_empty, 1);
        check("R1 overrun", rx_overrun, 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] op;
            logic [7:0] d, el, eq;
            {op, d, el, eq} = VEC[i];
            case (op)
                2'd0: push_rx(d);
                2'd1: pop_rx();
                default: begin ctl_wr = 1'b1; ctl_data = d; @(negedge clk); ctl_wr = 1'b0; end
            endcase
            @(negedge clk);
            check($sformatf("table row %0d level (R2 R3 R4 R5 R8 R9)", i), rx_level, el);
            if (el != 0)
                check($sformatf("table row %0d data (R8 R9)", i), rx_q, eq);
            if (i == 12) begin
                check("R3 still off", fifo_en, 0);
                check("R10 overrun in holding mode", rx_overrun, 1);
            end
        end

        // R2 enable from off; R10 flush clears overrun
        write_ctl(8'h01);
        check("R2 fifo_en", fifo_en, 1);
        check("R10 overrun cleared", rx_overrun, 0);

        // R7 capacity, R12 receive threshold
        for (int i = 0; i < 128; i++) push_rx(8'(i));
        check("R7 level full", rx_level, 128);
        check("R7 full flag", rx_full, 1);
        check("R12 rx_trig", rx_trig, 1);
        push_rx(8'hAA);
        check("R7 push when full", rx_level, 128);
        check("R10 overrun set", rx_overrun, 1);

        // R8 order
        bad_order = 0;
        for (int i = 0; i < 128; i++) begin
            if (rx_q != 8'(i)) bad_order++;
            pop_rx();
        end
        check("R8 order mismatches", bad_order, 0);
        check("R8 drained", rx_empty, 1);
        pop_rx();
        check("R8 pop empty", rx_level, 0);

        // R4 / R5 / R12 transmit
        for (int i = 0; i < 20; i++) push_tx(8'(i + 3));
        check("R12 tx_trig above", tx_trig, 0);
        check("R7 tx_q oldest", tx_q, 3);
        write_ctl(8'h03);
        check("R4 tx untouched", tx_level, 20);
        check("R10 cleared by rx clear", rx_overrun, 0);
        write_ctl(8'h05);
        check("R5 tx cleared", tx_level, 0);
        check("R12 tx_trig at zero", tx_trig, 1);

        // R11 clear beats push in the same cycle
        push_rx(8'h01);
        push_rx(8'h02);
        ctl_wr = 1'b1; ctl_data = 8'h03;
        @(negedge clk);
        ctl_wr = 1'b0;
        rx_push = 1'b1; rx_data = 8'h77;
        @(negedge clk);
        rx_push = 1'b0;
        check("R11 clear wins", rx_level, 0);
        @(negedge clk);
        // R6 request gone: next push stays
        push_rx(8'h88);
        @(negedge clk);
        check("R6 push kept", rx_level, 1);
        check("R6 data kept", rx_q, 8'h88);

        // R3 disable empties both
        push_tx(8'h99);
        write_ctl(8'h00);
        check("R3 fifo_en off", fifo_en, 0);
        check("R3 rx empty", rx_level, 0);
        check("R3 tx empty", tx_level, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule